// File: doc/BRIEF.md
# Debounced Four-Pin GPIO Port

This block is the general-purpose pin port of one line-interface channel. It has four pins, and a direction bit selects input or output for each pin on its own. An input pin goes through a two-flop synchronizer and then through a debounce filter. All four pins share one programmable window. The filtered level of an input pin can be read from the data field. An output pin drives the value that software last wrote to that same field.

The debounce counter advances only on a timebase tick with a 0.5 ms period. A 4-bit window code selects a required run of `code*4+5` ticks. That covers 2.5 ms at code 0 up to 32.5 ms at code 15. When external ringing mode is set, pin 1 is taken over as the ring-relay control output. It then drives the relay request whatever its direction bit holds.

Registers are reached through a 2-bit address, a write strobe and a combinational read port. The address map is: 0 direction (bit n = 1 makes pin n+1 an output), 1 pin data, 2 debounce code, 3 external ringing mode (bit 0).

Top module: `gpio_dbnc_port`

## Requirements
- R1: After reset all pins are inputs (pin_oe_o = 0), pin_o = 0, ringing mode is off, the debounce code is 0, every filtered level is 0, and every register reads back 0.
- R2: With ringing mode off, pin_oe_o bit n equals direction bit n (address 0). The direction register reads back the value written.
- R3: An output pin drives its data bit (address 1), and a pin that is not an output drives 0 on pin_o. Reading address 1 returns the written data bit for each output pin.
- R4: Reading address 1 returns the filtered level for each input pin.
- R5: With ringing mode set (address 3 bit 0 = 1), pin_oe_o[0] = 1 and pin_o[0] follows relay_i, whatever direction bit 0 holds. Pins 2 to 4 are unaffected.
- R6: A filtered level changes only after the synchronized input has differed from it on the required number of consecutive ticks. A return to the filtered level before that clears the count.
- R7: The required count is code*4+5 ticks: 5 at code 0, 9 at code 1, 65 at code 15. Rising and falling transitions need the same count.
- R8: Without ticks, no filtered level changes, however long the input stays at the opposite level.
- R9: A new debounce code applies from the next tick. A count already at or above the new requirement completes on that tick.
- R10: The debounce code register keeps only the 4 low write-data bits. Upper bits are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Debounce timebase strobe, one cycle every 0.5 ms |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| relay_i | input | 1 | Ring-relay request, driven on pin 1 in ringing mode |
| pin_i | input | 4 | Raw pin levels |
| pin_o | output | 4 | Pin output values |
| pin_oe_o | output | 4 | Pin output enables |

## Verification
The hardest condition to reach is a count left in progress when the debounce code is lowered below it. That state is never visible at the ports. The stimulus holds a pin high for ten ticks under a 13-tick window, so the filtered level is still 0. It then rewrites the code to 0 with no tick in between and shows that the level flips on exactly the next tick. Glitch restarts and the 65-tick window at code 15 are reached the same way, by counting issued ticks one pulse at a time.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
  typedef enum logic [1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_DBNC = 2'd2,
    ADDR_RING = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_dbnc_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 8,
  parameter int CODE_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0] filt_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                ring_o,
  output logic [DATA_W-1:0]   rdata_o
);
  reg_addr_e addr;
  logic      unused_wdata;

  assign addr         = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= '0;
      dout_o <= '0;
      code_o <= '0;
      ring_o <= 1'b0;
    end else if (we_i) begin
      unique case (addr)
        ADDR_DIR:  dir_o  <= wdata_i[NUM_PINS-1:0];
        ADDR_DATA: dout_o <= wdata_i[NUM_PINS-1:0];
        ADDR_DBNC: code_o <= wdata_i[CODE_W-1:0];
        ADDR_RING: ring_o <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_DIR:  rdata_o[NUM_PINS-1:0] = dir_o;
      ADDR_DATA: rdata_o[NUM_PINS-1:0] = (dir_o & dout_o) | (~dir_o & filt_i);
      ADDR_DBNC: rdata_o[CODE_W-1:0]   = code_o;
      ADDR_RING: rdata_o[0]            = ring_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_dbnc_cell.sv
module gpio_dbnc_cell #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             pin_i,
  output logic             sync_o,
  output logic             filt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W:0]         cnt_inc;
  logic                   hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end
  assign sync_o = sync_q[SYNC_STAGES-1];

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // >= so a lowered threshold finishes a long count on the next tick
  assign hit     = cnt_inc >= {1'b0, thr_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= 1'b0;
    end else if (sync_o == filt_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (hit) begin
        filt_o <= ~filt_o;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NUM_PINS  = 4,
  parameter int RELAY_PIN = 0
) (
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic                ring_i,
  input  logic                relay_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == RELAY_PIN) begin : g_relay
      assign pin_oe_o[i] = ring_i | dir_i[i];
      assign pin_o[i]    = ring_i ? relay_i : (dir_i[i] & dout_i[i]);
    end else begin : g_plain
      assign pin_oe_o[i] = dir_i[i];
      assign pin_o[i]    = dir_i[i] & dout_i[i];
    end
  end
endmodule

// File: rtl/gpio_dbnc_port.sv
module gpio_dbnc_port #(
  parameter int NUM_PINS       = 4,
  parameter int DATA_W         = 8,
  parameter int CODE_W         = 4,
  parameter int CNT_W          = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int TICKS_PER_STEP = 4,
  parameter int BASE_TICKS     = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                relay_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  logic [NUM_PINS-1:0] dir_q, dout_q, filt, sync;
  logic [CODE_W-1:0]   code_q;
  logic                ring_q;
  logic [CNT_W-1:0]    thr;

  assign thr = CNT_W'(code_q) * CNT_W'(TICKS_PER_STEP) + CNT_W'(BASE_TICKS);

  gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .filt_i  (filt),
    .dir_o   (dir_q),
    .dout_o  (dout_q),
    .code_o  (code_q),
    .ring_o  (ring_q),
    .rdata_o (reg_rdata_o)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cell
    gpio_dbnc_cell #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .thr_i  (thr),
      .pin_i  (pin_i[i]),
      .sync_o (sync[i]),
      .filt_o (filt[i])
    );
  end

  gpio_pin_mux #(.NUM_PINS(NUM_PINS), .RELAY_PIN(0)) u_mux (
    .dir_i    (dir_q),
    .dout_i   (dout_q),
    .ring_i   (ring_q),
    .relay_i  (relay_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: rtl/gpio_dbnc_port_chk.sv
module gpio_dbnc_port_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                relay_i,
  input logic                ring_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] dout_q,
  input logic [NUM_PINS-1:0] filt,
  input logic [NUM_PINS-1:0] sync,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (filt == '0 && pin_oe_o == '0 && pin_o == '0);
    end
  end

  // R2
  dir_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_q |-> pin_oe_o == dir_q);

  // R3
  out_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_o[NUM_PINS-1:1] == (dout_q[NUM_PINS-1:1] & pin_oe_o[NUM_PINS-1:1]));

  // R5
  relay_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_q |-> (pin_oe_o[0] && pin_o[0] == relay_i));

  // R8
  tick_paced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt) |-> $past(tick_i));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R6
    filt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(filt[i]) |-> $past(sync[i] != filt[i]));
  end
endmodule

bind gpio_dbnc_port gpio_dbnc_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .relay_i  (relay_i),
  .ring_q   (ring_q),
  .dir_q    (dir_q),
  .dout_q   (dout_q),
  .filt     (filt),
  .sync     (sync),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/gpio_dbnc_port_tb.sv
module gpio_dbnc_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       relay_i = 1'b0;
  logic [3:0] pin_i = 4'h0;
  logic [3:0] pin_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_dbnc_port u_dut (
    .clk_i, .rst_ni, .tick_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .relay_i, .pin_i, .pin_o, .pin_oe_o
  );

  // {we, addr, wdata, relay, exp_rdata, exp_oe, exp_o}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h03, 1'b0, 8'h03, 4'b0011, 4'b0000},
    {1'b1, 2'd1, 8'h05, 1'b0, 8'h01, 4'b0011, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 8'h03, 4'b0011, 4'b0001},
    {1'b1, 2'd3, 8'h01, 1'b0, 8'h01, 4'b0011, 4'b0000},
    {1'b0, 2'd3, 8'h00, 1'b1, 8'h01, 4'b0011, 4'b0001},
    {1'b1, 2'd0, 8'h00, 1'b1, 8'h00, 4'b0001, 4'b0001},
    {1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 4'b0001, 4'b0000},
    {1'b1, 2'd3, 8'h00, 1'b0, 8'h00, 4'b0000, 4'b0000},
    {1'b1, 2'd0, 8'h0C, 1'b0, 8'h0C, 4'b1100, 4'b0100},
    {1'b0, 2'd1, 8'h00, 1'b0, 8'h04, 4'b1100, 4'b0100},
    {1'b1, 2'd2, 8'h07, 1'b0, 8'h07, 4'b1100, 4'b0100},
    {1'b1, 2'd2, 8'hF3, 1'b0, 8'h03, 4'b1100, 4'b0100}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk_i); pin_i = p;
    repeat (3) @(negedge clk_i);
  endtask

  function automatic logic [7:0] rd_data();
    return reg_rdata_o;
  endfunction

  task automatic rd_status(input string tag, input logic [3:0] exp);
    @(negedge clk_i); reg_addr_i = 2'd1; #1;
    check(tag, rd_data(), {4'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a); #1;
      check("R1 reset rdata", reg_rdata_o, 8'h00);
    end
    check("R1 reset oe", {4'h0, pin_oe_o}, 8'h00);
    check("R1 reset o", {4'h0, pin_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 R3 R5 R10 register and pin table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      reg_we_i = VEC[v][27]; reg_addr_i = VEC[v][26:25];
      reg_wdata_i = VEC[v][24:17]; relay_i = VEC[v][16];
      @(negedge clk_i);
      reg_we_i = 1'b0; #1;
      check($sformatf("R2 R3 R5 R10 row %0d rdata", v), reg_rdata_o, VEC[v][15:8]);
      check($sformatf("R2 R3 R5 row %0d oe", v), {4'h0, pin_oe_o}, {4'h0, VEC[v][7:4]});
      check($sformatf("R3 R5 row %0d o", v), {4'h0, pin_o}, {4'h0, VEC[v][3:0]});
    end

    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R4 R7 code 0: rising needs 5 ticks
    set_pins(4'b0001);
    ticks(4);
    rd_status("R7 code0 after 4 ticks", 4'b0000);
    ticks(1);
    rd_status("R4 R7 code0 after 5 ticks", 4'b0001);

    // R7 falling, same count
    set_pins(4'b0000);
    ticks(4);
    rd_status("R7 fall after 4 ticks", 4'b0001);
    ticks(1);
    rd_status("R7 fall after 5 ticks", 4'b0000);

    // R6 glitch restarts count, code 1 = 9 ticks
    wr(2'd2, 8'h01);
    set_pins(4'b0010);
    ticks(6);
    set_pins(4'b0000);
    rd_status("R6 glitch ignored", 4'b0000);
    set_pins(4'b0010);
    ticks(8);
    rd_status("R6 count restarted", 4'b0000);
    ticks(1);
    rd_status("R6 R7 code1 after 9 ticks", 4'b0010);

    // R8 no ticks, no change
    set_pins(4'b1010);
    repeat (300) @(negedge clk_i);
    rd_status("R8 no tick hold", 4'b0010);

    // R9 code lowered mid-count
    set_pins(4'b0010);
    wr(2'd2, 8'h02);
    set_pins(4'b0011);
    ticks(10);
    rd_status("R9 before code change", 4'b0010);
    wr(2'd2, 8'h00);
    rd_status("R9 write alone no change", 4'b0010);
    ticks(1);
    rd_status("R9 completes next tick", 4'b0011);

    // R7 code 15: 65 ticks
    wr(2'd2, 8'h0F);
    set_pins(4'b0111);
    ticks(64);
    rd_status("R7 code15 after 64", 4'b0011);
    ticks(1);
    rd_status("R7 code15 after 65", 4'b0111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule